// File: doc/BRIEF.md
# Codec serial port frame controller

This block is the device end of a synchronous serial link between a sampling converter and its host. The host supplies a bit clock (nominally 256 bit clocks per sample period) and a one-cycle frame-sync pulse. After each accepted frame-sync, the block exchanges one 16-bit word in each direction on the serial data lines. The outbound word carries the converter's latest A/D sample. The inbound word carries a D/A sample, which is presented on a parallel port with a one-cycle valid strobe.

Two word formats are supported. In the 15+1 format, the least significant inbound bit asks for a control frame in the next frame period. The least significant outbound bit carries a master/slave indicator. In the 16-bit format, all bits are sample data.

Control frames read or write a small bank of 8-bit configuration registers. One register bit drives the FLAG pin. Another register bit enables phone mode. In phone mode, control frames return a synchronised snapshot of the 16-bit alternate-data monitor input.

Top module: `codec_serial_port`

## Requirements
- R1: After fsync is sampled high at edge k while no word is in progress, dout shows word bits 15 down to 0 after edges k+1 to k+16 (MSB first), and din is sampled at those same edges.
- R2: In 15+1 format, a data frame's outbound word is adcSample[15:1] followed by masterInd as bit 0, both captured at edge k.
- R3: After a data frame, daSample and a one-cycle daValid pulse appear after edge k+17. In 15+1 format daSample is the inbound word with bit 0 forced to 0.
- R4: When register 1 bit 0 is set (16-bit format), data frames send adcSample unchanged and deliver the full inbound word, and inbound bit 0 never requests a control frame.
- R5: In 15+1 format, a data frame with inbound bit 0 set makes the next accepted frame a control frame; otherwise the next frame is a data frame. Control frames never update daSample or pulse daValid.
- R6: A control frame with inbound bit 13 = 0 is a write. It loads bits 7:0 into the register addressed by bits 12:8 at edge k+17. The write is ignored if bits 15:14 are not both zero or the address has no register.
- R7: A control frame with inbound bit 13 = 1 is a read. Outbound bits 7:0 carry the addressed register (zero for an address with no register). Outbound bits 15:8 are zero when phone mode is off.
- R8: With phone mode on (register 2 bit 1), a control frame's outbound bits 15:8 are altData[15:8], and a write returns all 16 bits of altData. altData passes through a two-flop synchroniser and is captured at edge k.
- R9: The flag output equals register 2 bit 0 and changes only after the commit edge of a control write.
- R10: dout is 0 outside the 16 bit slots, and an fsync pulse that arrives while a word is in progress is ignored.
- R11: Reset clears all registers, dout, flag, daSample and daValid, and the first frame after reset is a data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync pulse from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| adcSample | input | 16 | Converted sample to be sent |
| masterInd | input | 1 | Master/slave indicator for bit 0 in 15+1 format |
| daSample | output | 16 | Received sample for the D/A path |
| daValid | output | 1 | One-cycle strobe when daSample updates |
| altData | input | 16 | Asynchronous alternate-data monitor word |
| flag | output | 1 | Host-controlled general-purpose output |

## Verification
Each serial bit is due one edge after the edge that consumes the matching input bit. The bench drives din and fsync on falling edges and reads dout on the following falling edge, so outbound bit 15-i is taken half a cycle after edge k+1+i. Parallel results (daSample, daValid) and register effects (flag, mode, phone) are due only after edge k+17, and the bench samples them on the falling edge just after it. Secondary frames are always preceded by a requesting data frame, and altData is settled hundreds of cycles before use, so the synchroniser delay never lies inside a checked window.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 5;

  // bit positions inside an inbound control word
  localparam int OP_BIT   = 13;
  localparam int ADDR_LSB = 8;

  typedef struct packed {
    logic       start;     // accept a frame-sync this edge
    logic       startSec;  // the accepted frame is a control frame
    logic       shiftEn;   // one of the 16 bit slots
    logic       patchRd;   // slot where read data replaces the low byte
    logic       commit;    // word complete, apply its effects
    logic       secFrame;  // current frame is a control frame
    logic [3:0] bitIdx;    // outbound bit position for this slot
  } cspStrobe_t;
endpackage

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import csp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fsync,
  input  logic       reqBit,
  input  logic       mode16,
  output cspStrobe_t st
);
  localparam logic [CNT_W-1:0] LAST_SLOT  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] PATCH_SLOT = CNT_W'(WORD_W - REG_W);

  logic             busy;
  logic             secPend;
  logic             secFrame;
  logic [CNT_W-1:0] slotCnt;

  always_comb begin
    st.start    = fsync & ~busy;
    st.startSec = secPend;
    st.shiftEn  = busy & (slotCnt < LAST_SLOT);
    st.patchRd  = busy & secFrame & (slotCnt == PATCH_SLOT);
    st.commit   = busy & (slotCnt == LAST_SLOT);
    st.secFrame = secFrame;
    st.bitIdx   = ~slotCnt[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      secPend  <= 1'b0;
      secFrame <= 1'b0;
      slotCnt  <= '0;
    end else if (st.start) begin
      busy     <= 1'b1;
      secFrame <= secPend;
      secPend  <= 1'b0;
      slotCnt  <= '0;
    end else if (busy) begin
      if (st.commit) begin
        busy <= 1'b0;
        if (!secFrame && !mode16 && reqBit) secPend <= 1'b1;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csp_datapath.sv
module csp_datapath
  import csp_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int MODE_REG = 1,
  parameter int MISC_REG = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cspStrobe_t        st,
  input  logic              din,
  input  logic [WORD_W-1:0] adcSample,
  input  logic              masterInd,
  input  logic [WORD_W-1:0] altData,
  output logic              dout,
  output logic [WORD_W-1:0] daSample,
  output logic              daValid,
  output logic              flag,
  output logic              reqBit,
  output logic              mode16
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(NUM_REGS);

  logic [WORD_W-1:0] altMeta, altSync;
  logic [WORD_W-1:0] shiftReg, outWord, wordSel;
  logic [REG_W-1:0]  regBank [NUM_REGS];
  logic [REG_W-1:0]  rdByte;
  logic [ADDR_W-1:0] earlyAddr, fullAddr;
  logic              earlyRead, phoneOn, wrOk;

  assign reqBit  = shiftReg[0];
  assign mode16  = regBank[MODE_REG][0];
  assign flag    = regBank[MISC_REG][0];
  assign phoneOn = regBank[MISC_REG][1];

  // after 8 slots the shift register holds inbound bits 15..8
  assign earlyAddr = shiftReg[ADDR_W-1:0];
  assign earlyRead = shiftReg[OP_BIT-ADDR_LSB];
  assign fullAddr  = shiftReg[ADDR_LSB +: ADDR_W];
  assign wrOk      = st.secFrame && !shiftReg[OP_BIT] &&
                     (shiftReg[WORD_W-1 -: 2] == 2'b00) && (fullAddr < REG_LIMIT);

  always_comb begin
    rdByte = '0;
    if (earlyAddr < REG_LIMIT) rdByte = regBank[earlyAddr[IDX_W-1:0]];
    wordSel = outWord;
    if (st.patchRd && earlyRead) wordSel[REG_W-1:0] = rdByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      altMeta <= '0;
      altSync <= '0;
    end else begin
      altMeta <= altData;
      altSync <= altMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      outWord  <= '0;
      dout     <= 1'b0;
    end else if (st.start) begin
      shiftReg <= '0;
      dout     <= 1'b0;
      if (st.startSec)
        outWord <= phoneOn ? altSync : '0;
      else
        outWord <= mode16 ? adcSample : {adcSample[WORD_W-1:1], masterInd};
    end else if (st.shiftEn) begin
      shiftReg <= {shiftReg[WORD_W-2:0], din};
      dout     <= wordSel[st.bitIdx];
      outWord  <= wordSel;
    end else begin
      dout <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      daSample <= '0;
      daValid  <= 1'b0;
    end else begin
      daValid <= 1'b0;
      if (st.commit && !st.secFrame) begin
        daSample <= mode16 ? shiftReg : {shiftReg[WORD_W-1:1], 1'b0};
        daValid  <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)
        regBank[g] <= '0;
      else if (st.commit && wrOk && (fullAddr == ADDR_W'(g)))
        regBank[g] <= shiftReg[REG_W-1:0];
    end
  end
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsync,
  input  logic              din,
  output logic              dout,
  input  logic [WORD_W-1:0] adcSample,
  input  logic              masterInd,
  output logic [WORD_W-1:0] daSample,
  output logic              daValid,
  input  logic [WORD_W-1:0] altData,
  output logic              flag
);
  cspStrobe_t st;
  logic       reqBit;
  logic       mode16;

  csp_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .fsync  (fsync),
    .reqBit (reqBit),
    .mode16 (mode16),
    .st     (st)
  );

  csp_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .din       (din),
    .adcSample (adcSample),
    .masterInd (masterInd),
    .altData   (altData),
    .dout      (dout),
    .daSample  (daSample),
    .daValid   (daValid),
    .flag      (flag),
    .reqBit    (reqBit),
    .mode16    (mode16)
  );
endmodule

// File: rtl/csp_checker.sv
module csp_checker
  import csp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input cspStrobe_t st,
  input logic       dout,
  input logic       daValid,
  input logic       flag
);
  // R10: serial output is quiet whenever the previous cycle was not a bit slot
  a_r10_dout_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !st.shiftEn |=> !dout);

  // R3: a completed data frame yields a valid strobe
  a_r3_valid_after_data: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && !st.secFrame) |=> daValid);

  // R3: the strobe lasts one cycle
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    daValid |=> !daValid);

  // R5: control frames leave the sample path alone
  a_r5_sec_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && st.secFrame) |=> !daValid);

  // R9: flag moves only after a commit
  a_r9_flag_stable: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(flag));
endmodule

bind codec_serial_port csp_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .st      (st),
  .dout    (dout),
  .daValid (daValid),
  .flag    (flag)
);

// File: tb/sim_codec_serial_port.sv
`timescale 1ns/1ps
module sim_codec_serial_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fsync = 1'b0;
  logic        din = 1'b0;
  logic        dout;
  logic [15:0] adcSample = '0;
  logic        masterInd = 1'b1;
  logic [15:0] daSample;
  logic        daValid;
  logic [15:0] altData = '0;
  logic        flag;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  codec_serial_port u0 (
    .clk(clk), .rstN(rstN), .fsync(fsync), .din(din), .dout(dout),
    .adcSample(adcSample), .masterInd(masterInd), .daSample(daSample),
    .daValid(daValid), .altData(altData), .flag(flag)
  );

  // {din word, adcSample, expected outbound word, expected daSample}; 15+1 format, masterInd = 1
  localparam logic [63:0] VEC [5] = '{
    {16'hA5A4, 16'h1234, 16'h1235, 16'hA5A4},
    {16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFE},
    {16'h0000, 16'h0000, 16'h0001, 16'h0000},
    {16'h7F3C, 16'h8000, 16'h8001, 16'h7F3C},
    {16'h5554, 16'hAAAA, 16'hAAAB, 16'h5554}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame period of 256 bit clocks; returns after the commit edge (k+17)
  task automatic runFrame(input logic [15:0] w, input int midPulse, output logic [15:0] got);
    repeat (238) @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    for (int i = 0; i < 16; i++) begin
      din   = w[15-i];
      fsync = (i == midPulse);
      @(negedge clk);
      got[15-i] = dout;
    end
    fsync = 1'b0;
    din   = 1'b0;
    @(negedge clk);
  endtask

  // data frame with the request bit set, then a control frame
  task automatic ctrlFrame(input logic [15:0] w, output logic [15:0] got);
    logic [15:0] junk;
    runFrame(16'h0001, -1, junk);
    chk("R5 request frame valid", {15'd0, daValid}, 16'd1);
    runFrame(w, -1, got);
    chk("R5 control frame no valid", {15'd0, daValid}, 16'd0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 dout", {15'd0, dout}, 16'd0);
    chk("R11 flag", {15'd0, flag}, 16'd0);
    chk("R11 daSample", daSample, 16'h0000);
    chk("R11 daValid", {15'd0, daValid}, 16'd0);
    rstN = 1'b1;

    // R1 R2 R3 table walk
    foreach (VEC[i]) begin
      adcSample = VEC[i][47:32];
      runFrame(VEC[i][63:48], -1, got);
      chk("R1 R2 outbound word", got, VEC[i][31:16]);
      chk("R3 daSample", daSample, VEC[i][15:0]);
      chk("R3 daValid", {15'd0, daValid}, 16'd1);
      @(negedge clk);
      chk("R3 daValid one cycle", {15'd0, daValid}, 16'd0);
      chk("R10 idle dout", {15'd0, dout}, 16'd0);
    end

    // R6 R9 write register 2 = 0x01 -> flag, phone off so reply is zero
    ctrlFrame(16'h0201, got);
    chk("R9 flag set", {15'd0, flag}, 16'd1);
    chk("R7 write reply phone off", got, 16'h0000);
    chk("R5 daSample kept", daSample, 16'h0000);

    // R7 read register 2
    ctrlFrame(16'h2200, got);
    chk("R7 read reg2", got, 16'h0001);

    // R6 write and read register 5
    ctrlFrame(16'h05C3, got);
    ctrlFrame(16'h2500, got);
    chk("R6 R7 reg5 readback", got, 16'h00C3);

    // R6 address without register: ignored, reads zero
    ctrlFrame(16'h09FF, got);
    ctrlFrame(16'h2900, got);
    chk("R7 unmapped read", got, 16'h0000);

    // R6 reserved bits set: write ignored
    ctrlFrame(16'h4277, got);
    chk("R6 reserved ignored flag", {15'd0, flag}, 16'd1);
    ctrlFrame(16'h2200, got);
    chk("R6 reserved ignored reg2", got, 16'h0001);

    // R5 no request: next frame is a data frame
    runFrame(16'h0200, -1, got);
    chk("R5 plain data frame", daSample, 16'h0200);
    runFrame(16'h0300, -1, got);
    chk("R5 still data frame", daSample, 16'h0300);
    chk("R9 flag unchanged", {15'd0, flag}, 16'd1);

    // R8 phone mode
    altData = 16'hBEEF;
    ctrlFrame(16'h0203, got);
    ctrlFrame(16'h0311, got);
    chk("R8 write returns altData", got, 16'hBEEF);
    ctrlFrame(16'h2200, got);
    chk("R8 read upper altData", got, 16'hBE03);
    ctrlFrame(16'h2300, got);
    chk("R8 reg3 written", got[7:0] == 8'h11 ? 16'd1 : 16'd0, 16'd1);

    // R10 fsync inside a word is ignored
    adcSample = 16'h0F0E;
    runFrame(16'h6666, 5, got);
    chk("R10 word intact", got, 16'h0F0F);
    chk("R10 daSample", daSample, 16'h6666);
    repeat (20) @(negedge clk);
    chk("R10 dout after ignored pulse", {15'd0, dout}, 16'd0);
    chk("R10 no extra frame", {15'd0, daValid}, 16'd0);

    // R4 16-bit format
    ctrlFrame(16'h0101, got);
    adcSample = 16'h4320;
    runFrame(16'h1235, -1, got);
    chk("R4 full outbound", got, 16'h4320);
    chk("R4 full inbound", daSample, 16'h1235);
    runFrame(16'h8001, -1, got);
    chk("R4 bit0 no request", daSample, 16'h8001);
    chk("R4 valid", {15'd0, daValid}, 16'd1);

    // R11 reset restores 15+1 format and clears flag
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk("R11 flag cleared", {15'd0, flag}, 16'd0);
    runFrame(16'h0001, -1, got);
    chk("R11 first frame data", got, 16'h4321);
    chk("R11 daSample", daSample, 16'h0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule